// File: doc/BRIEF.md
# Transmit/Receive Descriptor Ring Controller

This block is the descriptor-management core of a 10/100 Ethernet MAC. It owns one table of buffer descriptors. Each descriptor is a status/control word and a buffer address. A programmable boundary splits the table into a transmit ring, at the low indices, and a receive ring, which takes the remaining entries. Software fills descriptors through a 32-bit register bus. It hands a descriptor to hardware by setting its ownership bit: READY on the transmit side, EMPTY on the receive side.

The transmit walker waits until its current descriptor is owned by hardware. It then presents the buffer address, the frame length and the pad/CRC options to a frame-sender port, and holds them until that port reports completion with a 9-bit status. The receive walker always shows the current receive buffer and whether it is free. When the frame-receiver port reports a finished frame, it records the length and status. Both walkers give the descriptor back by clearing its ownership bit. Each walker moves to the next entry, or back to the first entry of its ring on a wrap mark. The block also keeps the interrupt source and mask registers. It raises a single interrupt line from them.

Register map (byte offsets): 0x000 interrupt source (write one to clear), 0x004 interrupt mask, 0x008 transmit descriptor count, 0x400 + 8·i status word of descriptor i, 0x404 + 8·i address word of descriptor i.

Top module: `bdr_ring_ctrl`

## Requirements
- R1: After reset the interrupt source and mask read 0, the transmit count reads 64, and tx_req, irq_o and rx_buf_ready are 0.
- R2: Writing byte offset 0x400+8·i stores the status word of descriptor i, and 0x404+8·i stores its buffer address; both read back unchanged.
- R3: A transmit count above 128 is stored as 128; 128 leaves no receive descriptors, so every arriving frame is dropped.
- R4: When the current transmit descriptor has bit 15 (READY) set, tx_req rises. It carries tx_addr from the address word, tx_len from bits 31:16, tx_pad from bit 12 and tx_crc from bit 11, all held stable until tx_done.
- R5: On tx_done the status word keeps bits 31:9 except bit 15, which is cleared, and takes tx_status in bits 8:0.
- R6: After a descriptor with bit 13 (WRAP) set is serviced, or the last descriptor of its ring, that ring's pointer returns to its first descriptor.
- R7: The receive ring starts at the index equal to the transmit count. rx_buf_ready shows bit 15 (EMPTY) of the current entry, and rx_buf_addr shows its address word. On rx_done into a free entry, bits 31:16 take rx_len, bits 8:0 take rx_status, and bit 15 is cleared.
- R8: rx_done while the current receive entry is not free leaves the table unchanged and sets source bit 4 (busy).
- R9: When a completed descriptor has bit 14 set, the walker sets one source bit. Transmit sets bit 1 if tx_status has any of bits 0, 2, 3, 8, and bit 0 otherwise. Receive sets bit 3 if rx_status has any of bits 0, 1, 2, 3, 5, 6, 7, else bit 6 if bit 8 (control frame), else bit 2. When bit 14 is clear, no source bit is set.
- R10: Writing the source register clears each bit written as one and leaves the others.
- R11: irq_o is high exactly when some source bit and its mask bit are both set.
- R12: Writing the transmit count returns both ring pointers to their first descriptor and abandons a transmit request in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| tx_req | output | 1 | Transmit buffer offered to the frame sender |
| tx_addr | output | 32 | Transmit buffer address |
| tx_len | output | 16 | Transmit frame length |
| tx_pad | output | 1 | Pad short frame |
| tx_crc | output | 1 | Append CRC |
| tx_done | input | 1 | Frame sender finished (one-cycle pulse) |
| tx_status | input | 9 | Transmit completion status |
| rx_done | input | 1 | Frame receiver finished a frame (one-cycle pulse) |
| rx_len | input | 16 | Received length including FCS |
| rx_status | input | 9 | Receive completion status |
| rx_buf_ready | output | 1 | Current receive descriptor is free |
| rx_buf_addr | output | 32 | Current receive buffer address |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a ring pointer that has been sent back by a WRAP mark before the ring's real end. From outside, that pointer can only be seen through which descriptor is serviced next. The bench therefore gives the transmit ring three entries, marks the middle one WRAP, and arms both the first and the third. The scoreboard accepts only the first, and the third must stay untouched. The receive side repeats this: it wraps onto an entry already filled, so the next frame must be dropped with the busy source set and the stored descriptor unchanged.

// File: rtl/bdr_pkg.sv
package bdr_pkg;
   // descriptor status word bit positions
   localparam int BIT_OWN  = 15;
   localparam int BIT_INT  = 14;
   localparam int BIT_WRAP = 13;
   localparam int BIT_PAD  = 12;
   localparam int BIT_CRC  = 11;
   localparam int STAT_W   = 9;

   // completion status bits that count as errors
   localparam logic [STAT_W-1:0] TX_ERR_BITS = 9'h10D;
   localparam logic [STAT_W-1:0] RX_ERR_BITS = 9'h0EF;
   localparam int RX_CTL_BIT = 8;

   // interrupt source bit positions
   localparam int IRQ_W    = 7;
   localparam int IRQ_TXOK = 0;
   localparam int IRQ_TXER = 1;
   localparam int IRQ_RXOK = 2;
   localparam int IRQ_RXER = 3;
   localparam int IRQ_BUSY = 4;
   localparam int IRQ_TXCF = 5;
   localparam int IRQ_RXCF = 6;

   typedef enum logic {TXW_IDLE, TXW_BUSY} txw_state_e;
endpackage

// File: rtl/bdr_table.sv
module bdr_table #(
   parameter int NUM_BD = 128,
   parameter int IDXW   = $clog2(NUM_BD)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bus_we,
   input  logic            bus_sel_addr,
   input  logic [IDXW-1:0] bus_idx,
   input  logic [31:0]     bus_wdata,
   output logic [31:0]     bus_rdata,
   input  logic            txw_we,
   input  logic [IDXW-1:0] txw_idx,
   input  logic [31:0]     txw_data,
   input  logic            rxw_we,
   input  logic [IDXW-1:0] rxw_idx,
   input  logic [31:0]     rxw_data,
   input  logic [IDXW-1:0] tx_rd_idx,
   output logic [31:0]     tx_rd_stat,
   output logic [31:0]     tx_rd_addr,
   input  logic [IDXW-1:0] rx_rd_idx,
   output logic [31:0]     rx_rd_stat,
   output logic [31:0]     rx_rd_addr
);
   logic [31:0] stat_q [NUM_BD];
   logic [31:0] addr_q [NUM_BD];

   for (genvar i = 0; i < NUM_BD; i++) begin : g_bd
      // walker write-back wins over a bus write to the same word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            stat_q[i] <= '0;
         else if (txw_we && txw_idx == IDXW'(i))
            stat_q[i] <= txw_data;
         else if (rxw_we && rxw_idx == IDXW'(i))
            stat_q[i] <= rxw_data;
         else if (bus_we && !bus_sel_addr && bus_idx == IDXW'(i))
            stat_q[i] <= bus_wdata;
      end

      always_ff @(posedge clk) begin
         if (bus_we && bus_sel_addr && bus_idx == IDXW'(i))
            addr_q[i] <= bus_wdata;
      end
   end

   assign bus_rdata  = bus_sel_addr ? addr_q[bus_idx] : stat_q[bus_idx];
   assign tx_rd_stat = stat_q[tx_rd_idx];
   assign tx_rd_addr = addr_q[tx_rd_idx];
   assign rx_rd_stat = stat_q[rx_rd_idx];
   assign rx_rd_addr = addr_q[rx_rd_idx];
endmodule

// File: rtl/bdr_tx_walker.sv
module bdr_tx_walker
   import bdr_pkg::*;
#(
   parameter int NUM_BD = 128,
   parameter int IDXW   = $clog2(NUM_BD),
   parameter int CNTW   = $clog2(NUM_BD + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic [CNTW-1:0]   ring_len,
   input  logic [31:STAT_W]  cur_ctl,
   input  logic [31:0]       cur_addr,
   output logic [IDXW-1:0]   ptr,
   output logic              tx_req,
   output logic [31:0]       tx_addr,
   output logic [15:0]       tx_len,
   output logic              tx_pad,
   output logic              tx_crc,
   input  logic              tx_done,
   input  logic [STAT_W-1:0] tx_status,
   output logic              wb_en,
   output logic [31:0]       wb_data,
   output logic              ev_ok,
   output logic              ev_err
);
   txw_state_e          state_q;
   logic [31:STAT_W]    ctl_q;
   logic [31:0]         addr_q;
   logic                at_end;
   logic                finish;

   assign at_end = ctl_q[BIT_WRAP] || (CNTW'(ptr) + CNTW'(1) == ring_len);
   assign finish = (state_q == TXW_BUSY) && tx_done && !restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= TXW_IDLE;
         ptr     <= '0;
         ctl_q   <= '0;
         addr_q  <= '0;
      end else if (restart) begin
         state_q <= TXW_IDLE;
         ptr     <= '0;
      end else if (state_q == TXW_IDLE) begin
         if (ring_len != '0 && cur_ctl[BIT_OWN]) begin
            state_q <= TXW_BUSY;
            ctl_q   <= cur_ctl;
            addr_q  <= cur_addr;
         end
      end else if (tx_done) begin
         state_q <= TXW_IDLE;
         ptr     <= at_end ? '0 : ptr + IDXW'(1);
      end
   end

   assign tx_req  = (state_q == TXW_BUSY);
   assign tx_addr = addr_q;
   assign tx_len  = ctl_q[31:16];
   assign tx_pad  = ctl_q[BIT_PAD];
   assign tx_crc  = ctl_q[BIT_CRC];

   assign wb_en   = finish;
   assign wb_data = {ctl_q[31:16], 1'b0, ctl_q[14:STAT_W], tx_status};
   assign ev_err  = finish && ctl_q[BIT_INT] && |(tx_status & TX_ERR_BITS);
   assign ev_ok   = finish && ctl_q[BIT_INT] && !(|(tx_status & TX_ERR_BITS));
endmodule

// File: rtl/bdr_rx_walker.sv
module bdr_rx_walker
   import bdr_pkg::*;
#(
   parameter int NUM_BD = 128,
   parameter int IDXW   = $clog2(NUM_BD),
   parameter int CNTW   = $clog2(NUM_BD + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic [CNTW-1:0]   tx_len_bd,
   input  logic [15:STAT_W]  cur_ctl,
   input  logic [31:0]       cur_addr,
   output logic [IDXW-1:0]   rd_idx,
   output logic              buf_ready,
   output logic [31:0]       buf_addr,
   input  logic              rx_done,
   input  logic [15:0]       rx_len,
   input  logic [STAT_W-1:0] rx_status,
   output logic              wb_en,
   output logic [31:0]       wb_data,
   output logic              ev_ok,
   output logic              ev_err,
   output logic              ev_ctl,
   output logic              ev_busy
);
   localparam logic [CNTW-1:0] FULL = CNTW'(NUM_BD);

   logic [IDXW-1:0] off_q;
   logic [CNTW-1:0] ring_len;
   logic            has_ring;
   logic            accept;
   logic            at_end;
   logic            is_err;

   assign ring_len  = FULL - tx_len_bd;
   assign has_ring  = (tx_len_bd < FULL);
   assign rd_idx    = IDXW'(CNTW'(off_q) + tx_len_bd);
   assign buf_ready = has_ring && cur_ctl[BIT_OWN];
   assign buf_addr  = cur_addr;
   assign accept    = rx_done && buf_ready && !restart;
   assign at_end    = cur_ctl[BIT_WRAP] || (CNTW'(off_q) + CNTW'(1) == ring_len);
   assign is_err    = |(rx_status & RX_ERR_BITS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         off_q <= '0;
      else if (restart)
         off_q <= '0;
      else if (accept)
         off_q <= at_end ? '0 : off_q + IDXW'(1);
   end

   assign wb_en   = accept;
   assign wb_data = {rx_len, 1'b0, cur_ctl[14:STAT_W], rx_status};
   assign ev_err  = accept && cur_ctl[BIT_INT] && is_err;
   assign ev_ctl  = accept && cur_ctl[BIT_INT] && !is_err && rx_status[RX_CTL_BIT];
   assign ev_ok   = accept && cur_ctl[BIT_INT] && !is_err && !rx_status[RX_CTL_BIT];
   assign ev_busy = rx_done && !buf_ready;
endmodule

// File: rtl/bdr_irq.sv
module bdr_irq
   import bdr_pkg::*;
#(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IRQ_W-1:0] set_vec,
   input  logic             clr_en,
   input  logic             mask_en,
   input  logic [IRQ_W-1:0] wdata,
   output logic [IRQ_W-1:0] src,
   output logic [IRQ_W-1:0] mask,
   output logic             irq_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src  <= '0;
         mask <= '0;
      end else begin
         // a new event in the same cycle survives the clear
         src <= (src & ~(clr_en ? wdata : '0)) | set_vec;
         if (mask_en)
            mask <= wdata;
      end
   end

   if (IRQ_REG) begin : g_reg_out
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= |(src & mask);
      end
      assign irq_o = irq_q;
   end else begin : g_comb_out
      assign irq_o = |(src & mask);
   end
endmodule

// File: rtl/bdr_ring_ctrl.sv
module bdr_ring_ctrl
   import bdr_pkg::*;
#(
   parameter int          NUM_BD   = 128,
   parameter int          ADDR_W   = 12,
   parameter int unsigned TBL_BASE = 32'h400,
   parameter bit          IRQ_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              tx_req,
   output logic [31:0]       tx_addr,
   output logic [15:0]       tx_len,
   output logic              tx_pad,
   output logic              tx_crc,
   input  logic              tx_done,
   input  logic [8:0]        tx_status,
   input  logic              rx_done,
   input  logic [15:0]       rx_len,
   input  logic [8:0]        rx_status,
   output logic              rx_buf_ready,
   output logic [31:0]       rx_buf_addr,
   output logic              irq_o
);
   localparam int IDXW = $clog2(NUM_BD);
   localparam int CNTW = $clog2(NUM_BD + 1);
   localparam logic [CNTW-1:0]   CNT_RST  = CNTW'(NUM_BD / 2);
   localparam logic [ADDR_W-1:0] BASE_V   = ADDR_W'(TBL_BASE);
   localparam logic [ADDR_W-1:0] A_SRC    = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(4);
   localparam logic [ADDR_W-1:0] A_TXCNT  = ADDR_W'(8);

   if (NUM_BD < 2 || (NUM_BD & (NUM_BD - 1)) != 0) begin : g_bad_depth
      $error("NUM_BD must be a power of two of at least 2");
   end
   if (TBL_BASE % (NUM_BD * 8) != 0 || TBL_BASE < 16 ||
       TBL_BASE + NUM_BD * 8 > (1 << ADDR_W)) begin : g_bad_base
      $error("descriptor window misaligned or outside the address space");
   end

   // bus decode
   logic            in_tbl;
   logic            ring_restart;
   logic [CNTW-1:0] tx_cnt_q;
   logic [31:0]     tbl_rdata;

   assign in_tbl       = (reg_addr[ADDR_W-1:IDXW+3] == BASE_V[ADDR_W-1:IDXW+3]);
   assign ring_restart = reg_we && (reg_addr == A_TXCNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tx_cnt_q <= CNT_RST;
      else if (ring_restart)
         tx_cnt_q <= (reg_wdata > 32'(NUM_BD)) ? CNTW'(NUM_BD) : CNTW'(reg_wdata);
   end

   // walkers and table
   logic [IDXW-1:0] tx_ptr;
   logic [IDXW-1:0] rx_idx;
   logic [31:0]     tx_cur_stat, tx_cur_addr, rx_cur_stat, rx_cur_addr;
   logic            txw_we, rxw_we;
   logic [31:0]     txw_data, rxw_data;
   logic            tx_ev_ok, tx_ev_err;
   logic            rx_ev_ok, rx_ev_err, rx_ev_ctl, rx_ev_busy;

   bdr_table #(.NUM_BD(NUM_BD), .IDXW(IDXW)) u_table (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_we       (reg_we && in_tbl),
      .bus_sel_addr (reg_addr[2]),
      .bus_idx      (reg_addr[IDXW+2:3]),
      .bus_wdata    (reg_wdata),
      .bus_rdata    (tbl_rdata),
      .txw_we       (txw_we),
      .txw_idx      (tx_ptr),
      .txw_data     (txw_data),
      .rxw_we       (rxw_we),
      .rxw_idx      (rx_idx),
      .rxw_data     (rxw_data),
      .tx_rd_idx    (tx_ptr),
      .tx_rd_stat   (tx_cur_stat),
      .tx_rd_addr   (tx_cur_addr),
      .rx_rd_idx    (rx_idx),
      .rx_rd_stat   (rx_cur_stat),
      .rx_rd_addr   (rx_cur_addr)
   );

   bdr_tx_walker #(.NUM_BD(NUM_BD), .IDXW(IDXW), .CNTW(CNTW)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (ring_restart),
      .ring_len  (tx_cnt_q),
      .cur_ctl   (tx_cur_stat[31:STAT_W]),
      .cur_addr  (tx_cur_addr),
      .ptr       (tx_ptr),
      .tx_req    (tx_req),
      .tx_addr   (tx_addr),
      .tx_len    (tx_len),
      .tx_pad    (tx_pad),
      .tx_crc    (tx_crc),
      .tx_done   (tx_done),
      .tx_status (tx_status),
      .wb_en     (txw_we),
      .wb_data   (txw_data),
      .ev_ok     (tx_ev_ok),
      .ev_err    (tx_ev_err)
   );

   bdr_rx_walker #(.NUM_BD(NUM_BD), .IDXW(IDXW), .CNTW(CNTW)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (ring_restart),
      .tx_len_bd (tx_cnt_q),
      .cur_ctl   (rx_cur_stat[15:STAT_W]),
      .cur_addr  (rx_cur_addr),
      .rd_idx    (rx_idx),
      .buf_ready (rx_buf_ready),
      .buf_addr  (rx_buf_addr),
      .rx_done   (rx_done),
      .rx_len    (rx_len),
      .rx_status (rx_status),
      .wb_en     (rxw_we),
      .wb_data   (rxw_data),
      .ev_ok     (rx_ev_ok),
      .ev_err    (rx_ev_err),
      .ev_ctl    (rx_ev_ctl),
      .ev_busy   (rx_ev_busy)
   );

   // interrupt sources
   logic [IRQ_W-1:0] irq_set, irq_src, irq_mask;

   always_comb begin
      irq_set           = '0;
      irq_set[IRQ_TXOK] = tx_ev_ok;
      irq_set[IRQ_TXER] = tx_ev_err;
      irq_set[IRQ_RXOK] = rx_ev_ok;
      irq_set[IRQ_RXER] = rx_ev_err;
      irq_set[IRQ_BUSY] = rx_ev_busy;
      irq_set[IRQ_TXCF] = 1'b0;
      irq_set[IRQ_RXCF] = rx_ev_ctl;
   end

   bdr_irq #(.IRQ_REG(IRQ_REG)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (irq_set),
      .clr_en  (reg_we && reg_addr == A_SRC),
      .mask_en (reg_we && reg_addr == A_MASK),
      .wdata   (reg_wdata[IRQ_W-1:0]),
      .src     (irq_src),
      .mask    (irq_mask),
      .irq_o   (irq_o)
   );

   // read-back
   always_comb begin
      if (in_tbl)                    reg_rdata = tbl_rdata;
      else if (reg_addr == A_SRC)    reg_rdata = 32'(irq_src);
      else if (reg_addr == A_MASK)   reg_rdata = 32'(irq_mask);
      else if (reg_addr == A_TXCNT)  reg_rdata = 32'(tx_cnt_q);
      else                           reg_rdata = '0;
   end
endmodule

// File: rtl/bdr_ring_chk.sv
module bdr_ring_chk #(
   parameter int NUM_BD = 128,
   parameter int IDXW   = $clog2(NUM_BD),
   parameter int CNTW   = $clog2(NUM_BD + 1)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            tx_req,
   input logic            tx_done,
   input logic [31:0]     tx_addr,
   input logic [15:0]     tx_len,
   input logic            ring_restart,
   input logic [CNTW-1:0] tx_cnt_q,
   input logic [IDXW-1:0] tx_ptr,
   input logic            rx_done,
   input logic            rx_buf_ready,
   input logic [6:0]      irq_src,
   input logic [6:0]      irq_mask,
   input logic            irq_o
);
   assert_clamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_cnt_q <= CNTW'(NUM_BD));

   assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req && !tx_done && !ring_restart |=> tx_req && $stable(tx_addr) && $stable(tx_len));

   assert_ptr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_cnt_q != '0 |-> CNTW'(tx_ptr) < tx_cnt_q);

   assert_busy_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done && !rx_buf_ready |=> irq_src[4]);

   assert_masked_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_mask == '0 && $past(irq_mask) == '0 |-> !irq_o);

   assert_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ring_restart |=> !tx_req && tx_ptr == '0);
endmodule

bind bdr_ring_ctrl bdr_ring_chk #(.NUM_BD(NUM_BD)) u_ring_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tx_req       (tx_req),
   .tx_done      (tx_done),
   .tx_addr      (tx_addr),
   .tx_len       (tx_len),
   .ring_restart (ring_restart),
   .tx_cnt_q     (tx_cnt_q),
   .tx_ptr       (tx_ptr),
   .rx_done      (rx_done),
   .rx_buf_ready (rx_buf_ready),
   .irq_src      (irq_src),
   .irq_mask     (irq_mask),
   .irq_o        (irq_o)
);

// File: tb/tb_bdr_ring_ctrl.sv
module tb_bdr_ring_ctrl;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        tx_req, tx_pad, tx_crc;
   logic [31:0] tx_addr;
   logic [15:0] tx_len;
   logic        tx_done = 1'b0;
   logic [8:0]  tx_status = '0;
   logic        rx_done = 1'b0;
   logic [15:0] rx_len = '0;
   logic [8:0]  rx_status = '0;
   logic        rx_buf_ready;
   logic [31:0] rx_buf_addr;
   logic        irq_o;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   typedef struct {
      logic [31:0] addr;
      logic [15:0] len;
      logic        pad;
      logic        crc;
      logic [8:0]  status;
   } tx_item_t;
   tx_item_t exp_q[$];

   bdr_ring_ctrl dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_req(tx_req),
      .tx_addr(tx_addr), .tx_len(tx_len), .tx_pad(tx_pad), .tx_crc(tx_crc),
      .tx_done(tx_done), .tx_status(tx_status), .rx_done(rx_done),
      .rx_len(rx_len), .rx_status(rx_status), .rx_buf_ready(rx_buf_ready),
      .rx_buf_addr(rx_buf_addr), .irq_o(irq_o)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   function automatic logic [11:0] bd_at(input int idx, input int word);
      return 12'(32'h400 + idx * 8 + word * 4);
   endfunction

   // driver: queue the expected request, then hand the descriptor over
   task automatic tx_arm(input int idx, input logic [31:0] addr, input logic [15:0] len,
                         input logic [15:9] ctl, input logic [8:0] status);
      tx_item_t it;
      it.addr = addr; it.len = len; it.pad = ctl[12]; it.crc = ctl[11]; it.status = status;
      exp_q.push_back(it);
      wr(bd_at(idx, 1), addr);
      wr(bd_at(idx, 0), {len, 1'b1, ctl[14:9], 9'h0});
   endtask

   task automatic tx_drain();
      while (exp_q.size() != 0) @(negedge clk);
      repeat (6) @(negedge clk);
   endtask

   task automatic rx_frame(input logic [15:0] len, input logic [8:0] status);
      @(negedge clk);
      rx_done = 1'b1; rx_len = len; rx_status = status;
      @(negedge clk);
      rx_done = 1'b0;
   endtask

   // monitor: compare each offered buffer with the scoreboard, then complete it
   initial begin
      forever begin
         @(negedge clk);
         if (tx_req) begin
            if (exp_q.size() == 0) begin
               chk("R4", "unexpected tx_req", 32'(tx_req), 32'h0);
               repeat (2) @(negedge clk);
               tx_done = 1'b1; tx_status = '0;
               @(negedge clk);
               tx_done = 1'b0;
            end else begin
               tx_item_t e;
               e = exp_q.pop_front();
               chk("R4", "tx_addr", tx_addr, e.addr);
               chk("R4", "tx_len", 32'(tx_len), 32'(e.len));
               chk("R4", "tx_pad", 32'(tx_pad), 32'(e.pad));
               chk("R4", "tx_crc", 32'(tx_crc), 32'(e.crc));
               repeat (2) @(negedge clk);
               tx_done = 1'b1; tx_status = e.status;
               @(negedge clk);
               tx_done = 1'b0;
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(12'h000, d); chk("R1", "source", d, 32'h0);
      rd(12'h004, d); chk("R1", "mask", d, 32'h0);
      rd(12'h008, d); chk("R1", "tx count", d, 32'd64);
      chk("R1", "tx_req", 32'(tx_req), 32'h0);
      chk("R1", "irq_o", 32'(irq_o), 32'h0);
      chk("R1", "rx_buf_ready", 32'(rx_buf_ready), 32'h0);

      // R2 table access
      wr(bd_at(5, 1), 32'hDEAD_BEE0);
      wr(bd_at(5, 0), 32'h1234_0000);
      rd(bd_at(5, 1), d); chk("R2", "address word", d, 32'hDEAD_BEE0);
      rd(bd_at(5, 0), d); chk("R2", "status word", d, 32'h1234_0000);

      // R3 clamp, and no receive ring at all
      wr(12'h008, 32'd200);
      rd(12'h008, d); chk("R3", "clamped count", d, 32'd128);
      chk("R3", "rx_buf_ready with empty ring", 32'(rx_buf_ready), 32'h0);
      rx_frame(16'd64, 9'h0);
      rd(12'h000, d); chk("R3", "busy on empty ring", d, 32'h10);
      wr(12'h000, 32'h7F);

      // R12 restart, three transmit entries
      wr(12'h008, 32'd3);
      rd(12'h008, d); chk("R12", "count stored", d, 32'd3);

      // R4 R5 R9 plain frame with interrupt request and CRC
      tx_arm(0, 32'h0000_1000, 16'd100, 7'b0100100, 9'h000);
      tx_drain();
      rd(bd_at(0, 0), d); chk("R5", "desc0 written back", d, 32'h0064_4800);
      rd(12'h000, d); chk("R9", "tx ok source", d, 32'h01);
      wr(12'h000, 32'h7F);

      // R5 R9 error completion on a WRAP entry
      tx_arm(1, 32'h0000_2000, 16'h0200, 7'b0110000, 9'h034);
      tx_drain();
      rd(bd_at(1, 0), d); chk("R5", "desc1 status", d, 32'h0200_6034);
      rd(12'h000, d); chk("R9", "tx error source", d, 32'h02);
      wr(12'h000, 32'h7F);

      // R6 WRAP returns to entry 0 although entry 2 is armed
      wr(bd_at(2, 0), 32'h0010_8000);
      tx_arm(0, 32'h0000_3000, 16'd40, 7'b0001000, 9'h002);
      tx_drain();
      rd(bd_at(0, 0), d); chk("R6", "desc0 serviced after wrap", d, 32'h0028_1002);
      rd(bd_at(2, 0), d); chk("R6", "desc2 untouched", d, 32'h0010_8000);
      rd(12'h000, d); chk("R9", "no source without request bit", d, 32'h0);
      chk("R4", "tx_req idle", 32'(tx_req), 32'h0);

      // R7 receive ring starts at index 3
      wr(bd_at(3, 1), 32'h0000_A000);
      wr(bd_at(3, 0), 32'h0000_C000);
      wr(bd_at(4, 1), 32'h0000_B000);
      wr(bd_at(4, 0), 32'h0000_E000);
      wr(bd_at(5, 0), 32'h0000_C000);
      @(negedge clk);
      chk("R7", "rx_buf_ready", 32'(rx_buf_ready), 32'h1);
      chk("R7", "rx_buf_addr", rx_buf_addr, 32'h0000_A000);
      rx_frame(16'd64, 9'h010);
      rd(bd_at(3, 0), d); chk("R7", "desc3 filled", d, 32'h0040_4010);
      rd(12'h000, d); chk("R9", "rx ok source", d, 32'h04);
      chk("R7", "next buffer", rx_buf_addr, 32'h0000_B000);
      wr(12'h000, 32'h7F);

      rx_frame(16'h05EE, 9'h002);
      rd(bd_at(4, 0), d); chk("R7", "desc4 filled", d, 32'h05EE_6002);
      rd(12'h000, d); chk("R9", "rx error source", d, 32'h08);
      chk("R6", "rx wrapped to desc3", rx_buf_addr, 32'h0000_A000);
      chk("R8", "rx_buf_ready on full entry", 32'(rx_buf_ready), 32'h0);
      wr(12'h000, 32'h7F);

      // R8 drop
      rx_frame(16'd80, 9'h000);
      rd(bd_at(3, 0), d); chk("R8", "desc3 unchanged", d, 32'h0040_4010);
      rd(12'h000, d); chk("R8", "busy source", d, 32'h10);

      // R10 selective clear
      wr(12'h000, 32'h01);
      rd(12'h000, d); chk("R10", "clear of unset bit keeps busy", d, 32'h10);
      wr(12'h000, 32'h10);
      rd(12'h000, d); chk("R10", "busy cleared", d, 32'h0);

      // R9 control frame
      wr(bd_at(3, 0), 32'h0000_C000);
      rx_frame(16'd64, 9'h100);
      rd(bd_at(3, 0), d); chk("R7", "control frame stored", d, 32'h0040_4100);
      rd(12'h000, d); chk("R9", "control source", d, 32'h40);

      // R11 mask
      chk("R11", "irq_o masked", 32'(irq_o), 32'h0);
      wr(12'h004, 32'h04);
      chk("R11", "irq_o other bit unmasked", 32'(irq_o), 32'h0);
      wr(12'h004, 32'h40);
      chk("R11", "irq_o raised", 32'(irq_o), 32'h1);
      wr(12'h000, 32'h40);
      chk("R11", "irq_o after clear", 32'(irq_o), 32'h0);

      // R12 restart moves the receive pointer back to desc3
      chk("R12", "rx pointer at desc4 before", rx_buf_addr, 32'h0000_B000);
      wr(12'h008, 32'd3);
      chk("R12", "rx pointer restarted", rx_buf_addr, 32'h0000_A000);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule